// File: doc/BRIEF.md
# Four-to-One Transmit Character Multiplexer

This block sits between wide, slow transmit logic and a narrow, fast character path. On each rising edge of a slow clock it takes a 40-bit transmit word: four data bytes, a special-character flag for each byte, and a flag per byte that forces the downstream encoder to assume a negative running disparity. On a fast clock running at exactly four times the slow rate, it sends that word out as four 10-bit characters, one per fast cycle.

The two clocks are phase related: every slow rising edge lines up with a fast rising edge. A toggle flag on the slow side tells the fast side where each slow period begins. From there a 2-bit phase counter picks which byte lane goes out. The output register is loaded only on fast rising edges, so a consumer that samples on the falling edge of the fast clock always sees a settled character. The delay from capture to output is fixed at four slow periods.

Top module: `txmux4to1`

## Requirements
- R1: While reset is high, and after reset until the first captured word reaches the output, `char_out` is all zeros.
- R2: Each output character holds the data byte in bits 7:0, that byte's special-character flag in bit 8 and that byte's force-negative-disparity flag in bit 9.
- R3: Flag bit n of `tx_kflag` and of `tx_negdisp` belongs to the byte in `tx_data` bits 8n+7 down to 8n.
- R4: The four characters of one word go out most significant byte first: bits 31:24, then 23:16, then 15:8, then 7:0.
- R5: A word captured at slow rising edge k drives its first character onto `char_out` at the fast rising edge that lines up with slow edge k+4. Its other three characters follow on the next three fast rising edges.
- R6: `char_out` changes only at fast rising edges. It holds steady through the falling edge of the fast clock.
- R7: Inputs are sampled only at slow rising edges. Changes to the inputs between those edges have no effect on the output.
- R8: Back-to-back words come out with no idle characters between them. Every fast cycle after the pipeline fills carries a character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Word clock, rising-edge active, one quarter of the fast rate |
| clk_fast | input | 1 | Character clock, four times the slow rate, phase aligned |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 32 | Four transmit bytes |
| tx_kflag | input | 4 | Special-character flag, one bit per byte |
| tx_negdisp | input | 4 | Force-negative-disparity flag, one bit per byte |
| char_out | output | 10 | Outgoing character: {force flag, special flag, byte} |

## Verification
Random words give every byte and flag value, so a swap of lanes or of bit fields shows up. A walking single flag sets one special-character bit per word and clears the matching force bit. It then sets every other flag to the opposite value, so that wrong pairing of flags with bytes (R3) and swapped bit 8 and bit 9 (R2) can each be told apart. Some words have noise applied between slow edges, and only the final value is held at the capture edge; these show that mid-period inputs are ignored. An unbroken run of words, with a check on every fast cycle, separates correct latency and ordering from a misaligned phase or an inserted gap. A second sample taken just before each rising edge separates a stable output from a glitching one.

// File: rtl/txmux_pkg.sv
package txmux_pkg;
  localparam int BYTE_W = 8;
  localparam int CHAR_W = BYTE_W + 2;

  // One outgoing character: force flag on top, special flag next, byte below.
  typedef struct packed {
    logic              neg_force;
    logic              kchar;
    logic [BYTE_W-1:0] octet;
  } char_t;
endpackage

// File: rtl/txmux_slow_pipe.sv
module txmux_slow_pipe
  import txmux_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 4
) (
  input  logic                      clk_slow,
  input  logic                      rst,
  input  logic [LANES*BYTE_W-1:0]   data_i,
  input  logic [LANES-1:0]          kflag_i,
  input  logic [LANES-1:0]          negf_i,
  output char_t [LANES-1:0]         word_o,
  output logic                      tog_o
);
  char_t [LANES-1:0] cap_w;
  char_t [LANES-1:0] stage_q [DEPTH];
  logic              tog_q;

  // Pair each byte with the flag bits of the same index.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cap_w[g] = '{neg_force: negf_i[g],
                        kchar:     kflag_i[g],
                        octet:     data_i[g*BYTE_W +: BYTE_W]};
  end

  always_ff @(posedge clk_slow) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
      tog_q <= 1'b0;
    end else begin
      stage_q[0] <= cap_w;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      tog_q <= ~tog_q;
    end
  end

  assign word_o = stage_q[DEPTH-1];
  assign tog_o  = tog_q;
endmodule

// File: rtl/txmux_phase.sv
module txmux_phase #(
  parameter int LANES = 4,
  localparam int PH_W = $clog2(LANES)
) (
  input  logic            clk_fast,
  input  logic            rst,
  input  logic            tog_i,
  output logic [PH_W-1:0] ph_o
);
  logic            tog_f;
  logic            slow_edge;
  logic [PH_W-1:0] ph_q;

  // The toggle is seen to move one fast cycle after the slow edge,
  // so the next fast edge is the third in the slow period (index 2).
  assign slow_edge = tog_i ^ tog_f;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      tog_f <= 1'b0;
      ph_q  <= '0;
    end else begin
      tog_f <= tog_i;
      if (slow_edge) ph_q <= PH_W'(2);
      else           ph_q <= ph_q + 1'b1;
    end
  end

  assign ph_o = ph_q;
endmodule

// File: rtl/txmux_lane_sel.sv
module txmux_lane_sel
  import txmux_pkg::*;
#(
  parameter int LANES = 4,
  localparam int PH_W = $clog2(LANES)
) (
  input  logic              clk_fast,
  input  logic              rst,
  input  logic [PH_W-1:0]   ph_i,
  input  char_t [LANES-1:0] word_i,
  output char_t             char_o
);
  localparam logic [PH_W-1:0] TOP_LANE = PH_W'(LANES-1);

  char_t [LANES-1:0] hold_q;
  char_t             char_q;

  // Phase 0 is the fast edge aligned with the slow edge. At that edge the
  // slow stage still shows the previous word, so the word is taken from
  // there and held for the three lanes that follow.
  always_ff @(posedge clk_fast) begin
    if (rst) begin
      hold_q <= '0;
      char_q <= '0;
    end else if (ph_i == '0) begin
      hold_q <= word_i;
      char_q <= word_i[LANES-1];
    end else begin
      char_q <= hold_q[TOP_LANE - ph_i];
    end
  end

  assign char_o = char_q;
endmodule

// File: rtl/txmux4to1.sv
module txmux4to1
  import txmux_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int LAT_SLOW = 4
) (
  input  logic                    clk_slow,
  input  logic                    clk_fast,
  input  logic                    rst,
  input  logic [LANES*BYTE_W-1:0] tx_data,
  input  logic [LANES-1:0]        tx_kflag,
  input  logic [LANES-1:0]        tx_negdisp,
  output logic [CHAR_W-1:0]       char_out
);
  localparam int PH_W = $clog2(LANES);

  char_t [LANES-1:0] word_w;
  logic              tog_w;
  logic [PH_W-1:0]   ph_w;
  char_t             char_w;

  txmux_slow_pipe #(.LANES(LANES), .DEPTH(LAT_SLOW)) u_pipe (
    .clk_slow (clk_slow),
    .rst      (rst),
    .data_i   (tx_data),
    .kflag_i  (tx_kflag),
    .negf_i   (tx_negdisp),
    .word_o   (word_w),
    .tog_o    (tog_w)
  );

  txmux_phase #(.LANES(LANES)) u_phase (
    .clk_fast (clk_fast),
    .rst      (rst),
    .tog_i    (tog_w),
    .ph_o     (ph_w)
  );

  txmux_lane_sel #(.LANES(LANES)) u_sel (
    .clk_fast (clk_fast),
    .rst      (rst),
    .ph_i     (ph_w),
    .word_i   (word_w),
    .char_o   (char_w)
  );

  assign char_out = char_w;
endmodule

// File: rtl/txmux4to1_chk.sv
module txmux4to1_chk #(
  parameter int LANES = 4
) (
  input logic                 clk_slow,
  input logic                 clk_fast,
  input logic                 rst,
  input logic [LANES*8-1:0]   tx_data,
  input logic [LANES-1:0]     tx_kflag,
  input logic [LANES-1:0]     tx_negdisp,
  input logic [9:0]           char_out
);
  // Counts slow edges since reset, saturating once the pipeline is full.
  logic [2:0] fill_cnt;
  always_ff @(posedge clk_slow) begin
    if (rst)                fill_cnt <= '0;
    else if (fill_cnt != 3'd5) fill_cnt <= fill_cnt + 3'd1;
  end

  // R1: first character after reset is idle.
  assert_idle_after_reset_R1: assert property (@(posedge clk_fast) disable iff (rst)
    $past(rst) |-> char_out == 10'd0);

  // R5 with R2: last lane of the word from five slow edges back is on the output.
  assert_lane0_latency_R5: assert property (@(posedge clk_slow) disable iff (rst)
    (fill_cnt == 3'd5) |->
      char_out == {$past(tx_negdisp[0], 5), $past(tx_kflag[0], 5), $past(tx_data[7:0], 5)});

  // R4: the top byte comes first, one fast cycle into the slow period.
  assert_msb_first_R4: assert property (@(posedge clk_fast) disable iff (rst)
    ($rose(clk_slow) && fill_cnt == 3'd5) |->
      char_out == {$past(tx_negdisp[3], 17), $past(tx_kflag[3], 17), $past(tx_data[31:24], 17)});

  // R3: the second character pairs bits 23:16 with flag index 2.
  assert_flag_pairing_R3: assert property (@(posedge clk_fast) disable iff (rst)
    (clk_slow && $past(clk_slow) && !$past(clk_slow, 2) && fill_cnt == 3'd5) |->
      char_out == {$past(tx_negdisp[2], 18), $past(tx_kflag[2], 18), $past(tx_data[23:16], 18)});
endmodule

bind txmux4to1 txmux4to1_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/txmux4to1_test.sv
module txmux4to1_test;
  localparam int FAST_PERIOD = 10;

  logic        clk_fast = 1'b0;
  logic        clk_slow = 1'b0;
  logic        div      = 1'b0;
  logic        rst      = 1'b1;
  logic [31:0] tx_data    = '0;
  logic [3:0]  tx_kflag   = '0;
  logic [3:0]  tx_negdisp = '0;
  logic [9:0]  char_out;

  int total = 0;
  int fails = 0;
  bit drive_done = 1'b0;
  bit mon_done   = 1'b0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  txmux4to1 uut (
    .clk_slow   (clk_slow),
    .clk_fast   (clk_fast),
    .rst        (rst),
    .tx_data    (tx_data),
    .tx_kflag   (tx_kflag),
    .tx_negdisp (tx_negdisp),
    .char_out   (char_out)
  );

  always #(FAST_PERIOD/2) clk_fast = ~clk_fast;

  // Slow clock derived from the fast one: rising edges line up.
  always @(posedge clk_fast) begin
    div <= ~div;
    if (div) clk_slow <= ~clk_slow;
  end

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply one word; the last value before the next slow edge is what counts.
  task automatic put_word(input logic [31:0] d, input logic [3:0] k, input logic [3:0] n,
                          input bit noisy, input string tag);
    if (noisy) begin
      tx_data = $urandom; tx_kflag = 4'($urandom); tx_negdisp = 4'($urandom);
      #20;
      tx_data = $urandom; tx_kflag = 4'($urandom); tx_negdisp = 4'($urandom);
      #10;
    end
    tx_data = d; tx_kflag = k; tx_negdisp = n;
    for (int l = 3; l >= 0; l--) begin
      exp_q.push_back({n[l], k[l], d[l*8 +: 8]});
      tag_q.push_back(tag);
    end
  endtask

  task automatic driver();
    bit first = 1'b1;
    int w = 0;
    for (int i = 0; i < 8; i++) begin
      if (!first) begin @(posedge clk_slow); #2; end
      first = 1'b0;
      put_word($urandom, 4'($urandom), 4'($urandom), 1'b0, "R2 R4 R5 R8 random");
    end
    // Walking flag: isolates flag-to-byte pairing and bit 8 versus bit 9.
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_slow); #2;
      put_word(32'h11223344 + 32'(i), 4'b0001 << i, ~(4'b0001 << i), 1'b0, "R3 R2 walking flag");
    end
    @(posedge clk_slow); #2;
    put_word(32'hFFFFFFFF, 4'hF, 4'hF, 1'b0, "R2 all ones");
    @(posedge clk_slow); #2;
    put_word(32'h00000000, 4'hA, 4'h5, 1'b0, "R2 R3 flags only");
    for (int i = 0; i < 8; i++) begin
      @(posedge clk_slow); #2;
      put_word($urandom, 4'($urandom), 4'($urandom), 1'b1, "R7 mid-period noise");
    end
    for (int i = 0; i < 20; i++) begin
      @(posedge clk_slow); #2;
      w = i;
      put_word({8'(w), 8'(w+1), 8'(w+2), 8'(w+3)}, 4'(w), 4'(w+5), 1'b0, "R8 R4 back-to-back");
    end
    for (int i = 0; i < 2; i++) begin
      @(posedge clk_slow); #2;
      put_word(32'h0, 4'h0, 4'h0, 1'b0, "R5 drain");
    end
    drive_done = 1'b1;
  endtask

  task automatic monitor();
    logic [9:0] seen;
    @(posedge clk_slow); // first capture edge after reset release
    // R1: idle until the first word has crossed four slow periods.
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_fast);
      check("R1 idle before first word", char_out, 10'd0);
    end
    while (!(drive_done && exp_q.size() == 0)) begin
      @(negedge clk_fast);
      seen = char_out;
      if (exp_q.size() == 0) check("R8 missing expected word", seen, 10'h3FF);
      else check(tag_q.pop_front(), seen, exp_q.pop_front());
      #4;
      check("R6 stable until next rising edge", char_out, seen);
    end
    mon_done = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk_slow);
    @(negedge clk_fast);
    check("R1 reset value", char_out, 10'd0);
    @(posedge clk_slow); #2;
    check("R1 reset value late", char_out, 10'd0);
    rst = 1'b0;
    fork
      driver();
      monitor();
    join
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(FAST_PERIOD * 200000);
    if (!mon_done) begin
      total++;
      fails++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule